// File: doc/BRIEF.md
# Branch Condition Evaluation Unit

This block keeps the four status flags of a processor core (negative, zero, carry, overflow) and decides whether an instruction that carries a 4-bit condition field may go ahead. A compare strobe loads the flags from the difference of two operands. A separate set-flags strobe loads the flags from a result produced elsewhere in the datapath. Between such strobes the flags hold their value.

The evaluation side is combinational. The condition field presented on `cond_code` is tested against the held flags, and `exec_ok` reports whether the instruction executes or the branch is taken. Equality tests are supported, along with two families of ordering tests: signed and unsigned. The same flag state can give opposite answers in the two families. One code always executes. Codes that are not assigned never execute.

A parameter selects an optional forwarding path. With forwarding on, a condition tested in the same cycle as a flag-setting strobe sees the new flags. With forwarding off (the default), it sees the flags that are registered.

Top module: `branch_cond_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, the flags read 0 on `flags_out` until the first flag-setting strobe. `flags_out` is packed as {N, Z, C, V} in bits 3 down to 0.
- R2: A cycle with `cmp_en` high loads the flags from `opnd_a - opnd_b` at the next rising clock edge. N becomes the top bit of the difference, and Z is set exactly when the difference is zero.
- R3: On a compare, C is set exactly when `opnd_a >= opnd_b` as unsigned numbers (no borrow). V is set exactly when the signed subtraction overflows.
- R4: A cycle with `set_en` high and `cmp_en` low loads `set_flags_in` (packed as {N, Z, C, V}) into the flags at the next edge. When both strobes are high, the compare result is loaded.
- R5: In a cycle with both strobes low, the flags keep their value, whatever the operands are.
- R6: `exec_ok` follows `cond_code` and the held flags with no clock delay. Code 1110 (always) gives 1 under every flag state.
- R7: Code 0000 (equal) gives Z. Code 0001 (not equal) gives not Z.
- R8: Unsigned tests: code 0010 (higher-or-same) gives C, 0011 (lower) gives not C, 1000 (higher) gives C and not Z, and 1001 (lower-or-same) gives not C or Z.
- R9: Signed tests: code 1010 (greater-or-equal) gives N == V, 1011 (less-than) gives N != V, 1100 (greater-than) gives not Z and N == V, and 1101 (less-or-equal) gives Z or N != V.
- R10: The unassigned codes 0100, 0101, 0110, 0111 and 1111 give `exec_ok` = 0.
- R11: After a compare of 0xFFFFFFFF with 0x00000001, code 0011 (lower) gives 0 and code 1011 (less-than) gives 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmp_en | input | 1 | Compare strobe: load flags from opnd_a - opnd_b |
| opnd_a | input | DATA_W | Compare minuend |
| opnd_b | input | DATA_W | Compare subtrahend |
| set_en | input | 1 | Set-flags strobe: load flags from set_flags_in |
| set_flags_in | input | 4 | Externally produced flags {N, Z, C, V} |
| cond_code | input | 4 | Condition field of the instruction under test |
| exec_ok | output | 1 | 1 when the condition holds |
| flags_out | output | 4 | Held flags {N, Z, C, V} |

## Verification
A flag-setting strobe has its effect one rising edge later. The bench drives the strobe on a falling edge, drops it on the next falling edge, and only then reads `flags_out`. At that point exactly one edge lies between stimulus and check. `exec_ok` has no register in its path, so each condition code is applied on a falling edge and sampled half a nanosecond later, within the same cycle. For every flag state reached, the bench sweeps all sixteen codes and compares the result against the requirement rules.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

   localparam int FLAG_W = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   typedef enum logic [3:0] {
      CC_EQ = 4'b0000,
      CC_NE = 4'b0001,
      CC_HS = 4'b0010,
      CC_LO = 4'b0011,
      CC_HI = 4'b1000,
      CC_LS = 4'b1001,
      CC_GE = 4'b1010,
      CC_LT = 4'b1011,
      CC_GT = 4'b1100,
      CC_LE = 4'b1101,
      CC_AL = 4'b1110
   } cond_e;

endpackage

// File: rtl/bcu_sub_flags.sv
module bcu_sub_flags
   import bcu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output flags_t            f
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W:0]   wide;
   logic [DATA_W-1:0] diff;

   initial begin
      if (DATA_W < 2) $error("bcu_sub_flags: DATA_W must be at least 2");
   end

   always_comb begin
      // a + ~b + 1 : carry out means no borrow
      wide = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, 1'b1};
      diff = wide[DATA_W-1:0];
      f.n  = diff[MSB];
      f.z  = (diff == '0);
      f.c  = wide[DATA_W];
      f.v  = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
   end
endmodule

// File: rtl/bcu_flag_reg.sv
module bcu_flag_reg
   import bcu_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   cmp_en,
   input  logic   set_en,
   input  flags_t cmp_flags,
   input  flags_t ext_flags,
   output flags_t next_flags,
   output flags_t cur_flags
);
   always_comb begin
      if (cmp_en)      next_flags = cmp_flags;
      else if (set_en) next_flags = ext_flags;
      else             next_flags = cur_flags;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_flags <= '0;
      else        cur_flags <= next_flags;
   end
endmodule

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
   import bcu_pkg::*;
(
   input  flags_t     f,
   input  logic [3:0] code,
   output logic       take
);
   logic sgn_ge;

   always_comb begin
      sgn_ge = (f.n == f.v);
      case (code)
         CC_EQ:   take = f.z;
         CC_NE:   take = !f.z;
         CC_HS:   take = f.c;
         CC_LO:   take = !f.c;
         CC_HI:   take = f.c && !f.z;
         CC_LS:   take = !f.c || f.z;
         CC_GE:   take = sgn_ge;
         CC_LT:   take = !sgn_ge;
         CC_GT:   take = !f.z && sgn_ge;
         CC_LE:   take = f.z || !sgn_ge;
         CC_AL:   take = 1'b1;
         default: take = 1'b0;
      endcase
   end
endmodule

// File: rtl/branch_cond_unit.sv
module branch_cond_unit
   import bcu_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter bit FORWARD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmp_en,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              set_en,
   input  logic [3:0]        set_flags_in,
   input  logic [3:0]        cond_code,
   output logic              exec_ok,
   output logic [3:0]        flags_out
);
   flags_t cmp_f, next_f, cur_f, eval_f;

   initial begin
      if (DATA_W < 2) $error("branch_cond_unit: DATA_W must be at least 2");
   end

   bcu_sub_flags #(.DATA_W(DATA_W)) u_sub (
      .a (opnd_a),
      .b (opnd_b),
      .f (cmp_f)
   );

   bcu_flag_reg u_reg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmp_en     (cmp_en),
      .set_en     (set_en),
      .cmp_flags  (cmp_f),
      .ext_flags  (flags_t'(set_flags_in)),
      .next_flags (next_f),
      .cur_flags  (cur_f)
   );

   generate
      if (FORWARD) begin : g_fwd
         assign eval_f = next_f;
      end else begin : g_reg
         assign eval_f = cur_f;
      end
   endgenerate

   bcu_cond_eval u_eval (
      .f    (eval_f),
      .code (cond_code),
      .take (exec_ok)
   );

   assign flags_out = cur_f;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmp_en,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic              set_en,
   input logic [3:0]        set_flags_in,
   input logic [3:0]        cond_code,
   input logic              exec_ok,
   input logic [3:0]        flags_out
);
   // R1
   a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> flags_out == 4'b0000);

   // R2
   a_r2_zero_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en && (opnd_a == opnd_b) |=> flags_out[2]);

   // R3
   a_r3_borrow_clears_c: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en && (opnd_a < opnd_b) |=> !flags_out[1]);

   a_r3_signed_less: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en && ($signed(opnd_a) < $signed(opnd_b)) |=> flags_out[3] != flags_out[0]);

   // R4
   a_r4_set_load: assert property (@(posedge clk) disable iff (!rst_n)
      set_en && !cmp_en |=> flags_out == $past(set_flags_in));

   // R5
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en && !set_en |=> $stable(flags_out));

   // R6
   a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
      cond_code == 4'b1110 |-> exec_ok);

   // R10
   a_r10_unassigned: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_code[3:2] == 2'b01 || cond_code == 4'b1111) |-> !exec_ok);
endmodule

bind branch_cond_unit bcu_checker #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmp_en       (cmp_en),
   .opnd_a       (opnd_a),
   .opnd_b       (opnd_b),
   .set_en       (set_en),
   .set_flags_in (set_flags_in),
   .cond_code    (cond_code),
   .exec_ok      (exec_ok),
   .flags_out    (flags_out)
);

// File: tb/branch_cond_unit_test.sv
`timescale 1ns/100ps
module branch_cond_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_en = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        set_en = 1'b0;
   logic [3:0]  set_flags_in = '0;
   logic [3:0]  cond_code = '0;
   logic        exec_ok;
   logic [3:0]  flags_out;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   branch_cond_unit #(.DATA_W(32), .FORWARD(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .set_en(set_en), .set_flags_in(set_flags_in), .cond_code(cond_code),
      .exec_ok(exec_ok), .flags_out(flags_out)
   );

   // expected flags {N,Z,C,V} from the requirement rules (R2, R3)
   function automatic logic [3:0] model_flags(input logic [31:0] a, input logic [31:0] b);
      longint sa, sb, sd;
      logic [31:0] d;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      sd = sa - sb;
      d  = a - b;
      return {d[31], (a == b), (a >= b), (sd > 64'sd2147483647 || sd < -64'sd2147483648)};
   endfunction

   // expected condition outcome (R6..R10)
   function automatic logic model_take(input logic [3:0] f, input logic [3:0] code);
      logic n, z, c, v;
      {n, z, c, v} = f;
      case (code)
         4'b0000: return z;
         4'b0001: return !z;
         4'b0010: return c;
         4'b0011: return !c;
         4'b1000: return c & !z;
         4'b1001: return !c | z;
         4'b1010: return n == v;
         4'b1011: return n != v;
         4'b1100: return !z & (n == v);
         4'b1101: return z | (n != v);
         4'b1110: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic sweep_codes(input logic [3:0] f);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         cond_code = 4'(k);
         #0.5;
         check($sformatf("R6-code%0d", k), {3'b0, exec_ok}, {3'b0, model_take(f, 4'(k))});
      end
   endtask

   task automatic do_cmp(input logic [31:0] a, input logic [31:0] b);
      @(negedge clk);
      opnd_a = a; opnd_b = b; cmp_en = 1'b1;
      @(negedge clk);
      cmp_en = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 flags in reset", flags_out, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 flags after reset", flags_out, 4'b0000);
      sweep_codes(4'b0000);
   endtask

   task automatic t_cmp(input logic [31:0] a, input logic [31:0] b, input string tag);
      logic [3:0] e;
      e = model_flags(a, b);
      do_cmp(a, b);
      check({"R2 R3 ", tag}, flags_out, e);
      sweep_codes(e);
   endtask

   task automatic t_r11();
      do_cmp(32'hFFFF_FFFF, 32'h0000_0001);
      check("R11 flags", flags_out, 4'b1010);
      @(negedge clk); cond_code = 4'b0011; #0.5;
      check("R11 lower false", {3'b0, exec_ok}, 4'b0000);
      @(negedge clk); cond_code = 4'b1011; #0.5;
      check("R11 less-than true", {3'b0, exec_ok}, 4'b0001);
   endtask

   task automatic t_set();
      @(negedge clk);
      set_flags_in = 4'b1011; set_en = 1'b1;
      @(negedge clk);
      set_en = 1'b0;
      check("R4 set load", flags_out, 4'b1011);
      sweep_codes(4'b1011);
      @(negedge clk);
      set_flags_in = 4'b0001; set_en = 1'b1; cmp_en = 1'b1;
      opnd_a = 32'd9; opnd_b = 32'd9;
      @(negedge clk);
      set_en = 1'b0; cmp_en = 1'b0;
      check("R4 compare wins", flags_out, 4'b0110);
   endtask

   task automatic t_hold();
      logic [3:0] held;
      held = flags_out;
      @(negedge clk);
      opnd_a = 32'h8000_0000; opnd_b = 32'h1; set_flags_in = 4'b1111;
      repeat (3) @(negedge clk);
      check("R5 hold", flags_out, held);
      sweep_codes(held);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++; n_errs++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      #1;
      t_reset();
      t_cmp(32'd5, 32'd5, "equal");             // R7: Z=1 C=1
      t_cmp(32'd3, 32'd7, "unsigned lower");    // R8: borrow
      t_cmp(32'd7, 32'd3, "higher");            // R8 R9
      t_cmp(32'h8000_0000, 32'd1, "overflow");  // R3 R9: V=1
      t_cmp(32'h7FFF_FFFF, 32'hFFFF_FFFF, "pos overflow"); // R3
      t_cmp(32'h0, 32'h0, "zero");              // R7 R10
      t_r11();
      t_set();
      t_hold();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule